// File: doc/BRIEF.md
# Tagged Translation Buffer with Address-Space Flush

This block is a small fully associative translation buffer for a processor memory pipeline. Every slot holds a virtual page tag, the address space number (ASN) of the process that owns the mapping, a global bit, a physical page number, and read and write enable masks with one bit per privilege mode. A lookup presents a virtual page number together with the current ASN. One cycle later the block returns a hit flag, the physical page and the stored attributes. The page table walk that handles a miss lives outside this block.

New translations go into the slot named by a rotating replacement pointer. Three flush commands act on the table. One clears every slot. One clears every slot whose global bit is clear, so shared kernel mappings stay resident. One clears a single translation, chosen by page and ASN. When commands collide in the same cycle, a flush wins over a fill, and a fill wins over a lookup.

Top module: `asn_tlb`

## Requirements
- R1: After reset, every slot is invalid and `res_valid_o` is 0. The replacement pointer starts at slot 0.
- R2: A lookup that is accepted raises `res_valid_o` for exactly one cycle, in the cycle after the request. `res_valid_o` is 0 in every other cycle.
- R3: A lookup hits only when three things hold: the slot is valid, its tag equals the lookup page, and its ASN equals the lookup ASN or its global bit is 1. A hit returns that slot's physical page, global bit and mode masks.
- R4: A lookup of a non-global page with a different ASN misses. On a miss, `res_ppn_o`, `res_glob_o`, `res_rd_en_o` and `res_wr_en_o` are all zero.
- R5: Each accepted fill writes the slot named by the pointer, and the pointer then advances by one. After slot NUM_ENTRIES-1 it wraps to 0, so fill number NUM_ENTRIES+1 overwrites the first one.
- R6: `flush_op_i` = 1 (flush all) invalidates every slot, global ones included.
- R7: `flush_op_i` = 2 (flush process) invalidates every slot whose global bit is 0, whatever its ASN, and keeps the global slots.
- R8: `flush_op_i` = 3 (flush address) invalidates exactly the slots that a lookup with `flush_vpn_i`/`flush_asn_i` would hit. All other slots are kept.
- R9: A flush (`flush_op_i` != 0) blocks any fill or lookup in the same cycle. A fill blocks any lookup in the same cycle. A blocked fill writes nothing and does not move the pointer. A blocked lookup produces no result.
- R10: When several slots match a lookup, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page |
| lkp_asn_i | input | ASN_W | Current address space number |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | VPN_W | Fill virtual page tag |
| fill_asn_i | input | ASN_W | Fill owner ASN |
| fill_glob_i | input | 1 | Fill global bit |
| fill_ppn_i | input | PPN_W | Fill physical page |
| fill_rd_en_i | input | MODES | Fill per-mode read enables |
| fill_wr_en_i | input | MODES | Fill per-mode write enables |
| flush_op_i | input | 2 | 0 none, 1 all, 2 process, 3 address |
| flush_vpn_i | input | VPN_W | Page for the address flush |
| flush_asn_i | input | ASN_W | ASN for the address flush |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup hit |
| res_ppn_o | output | PPN_W | Physical page on hit, else 0 |
| res_glob_o | output | 1 | Global bit on hit, else 0 |
| res_rd_en_o | output | MODES | Read enables on hit, else 0 |
| res_wr_en_o | output | MODES | Write enables on hit, else 0 |

## Verification
The bench aims at the places where ASN and global handling is easy to get wrong. A global slot must still hit under a different ASN and must survive a process flush. A design that ignored the global bit would miss that slot or drop it. An address flush that compared only the tag would also remove another process's mapping of the same page. The bench fills one slot past the table size, and a pointer that failed to wrap would leave the oldest entry in place. It issues colliding commands to check that a dropped fill leaves the table and the pointer unchanged. It loads duplicate tags so that a result taken from the wrong slot would show up as a wrong physical page.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_ALL  = 2'd1,
    FL_PROC = 2'd2,
    FL_ADDR = 2'd3
  } flush_op_e;
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0]            glob_i,
  input  logic [N-1:0][VPN_W-1:0] tag_i,
  input  logic [N-1:0][ASN_W-1:0] asn_i,
  input  logic [VPN_W-1:0]        key_vpn_i,
  input  logic [ASN_W-1:0]        key_asn_i,
  output logic [N-1:0]            match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic tag_eq, asn_ok;
    assign tag_eq     = (tag_i[g] == key_vpn_i);
    assign asn_ok     = glob_i[g] || (asn_i[g] == key_asn_i);
    assign match_o[g] = valid_i[g] && tag_eq && asn_ok;
  end
endmodule

// File: rtl/tlb_prio_mux.sv
module tlb_prio_mux #(
  parameter int N = 16,
  parameter int W = 26
) (
  input  logic [N-1:0]        match_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic                hit_o,
  output logic [W-1:0]        data_o
);
  assign hit_o = |match_i;

  // lowest index wins
  always_comb begin
    data_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) data_o = data_i[i];
    end
  end
endmodule

// File: rtl/tlb_slot_ptr.sv
module tlb_slot_ptr #(
  parameter int N   = 16,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 20,
  parameter int ASN_W       = 8,
  parameter int PPN_W       = 16,
  parameter int MODES       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  input  logic [ASN_W-1:0] lkp_asn_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [ASN_W-1:0] fill_asn_i,
  input  logic             fill_glob_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [MODES-1:0] fill_rd_en_i,
  input  logic [MODES-1:0] fill_wr_en_i,
  input  logic [1:0]       flush_op_i,
  input  logic [VPN_W-1:0] flush_vpn_i,
  input  logic [ASN_W-1:0] flush_asn_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [PPN_W-1:0] res_ppn_o,
  output logic             res_glob_o,
  output logic [MODES-1:0] res_rd_en_o,
  output logic [MODES-1:0] res_wr_en_o
);
  localparam int N    = NUM_ENTRIES;
  localparam int PW   = (N > 1) ? $clog2(N) : 1;
  localparam int PL_W = PPN_W + 1 + 2 * MODES;

  logic [N-1:0]            valid_q, glob_q;
  logic [N-1:0][VPN_W-1:0] tag_q;
  logic [N-1:0][ASN_W-1:0] asn_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;
  logic [N-1:0][MODES-1:0] rd_q, wr_q;
  logic [PW-1:0]           slot_ptr;

  flush_op_e flush_op;
  logic      flush_act, fill_acc, lkp_acc;

  assign flush_op  = flush_op_e'(flush_op_i);
  assign flush_act = (flush_op != FL_NONE);
  assign fill_acc  = fill_valid_i && !flush_act;
  assign lkp_acc   = lkp_valid_i && !flush_act && !fill_valid_i;

  logic [N-1:0] lkp_match, fl_match;

  tlb_entry_cmp #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lkp_cmp (
    .valid_i   (valid_q),
    .glob_i    (glob_q),
    .tag_i     (tag_q),
    .asn_i     (asn_q),
    .key_vpn_i (lkp_vpn_i),
    .key_asn_i (lkp_asn_i),
    .match_o   (lkp_match)
  );

  tlb_entry_cmp #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_cmp (
    .valid_i   (valid_q),
    .glob_i    (glob_q),
    .tag_i     (tag_q),
    .asn_i     (asn_q),
    .key_vpn_i (flush_vpn_i),
    .key_asn_i (flush_asn_i),
    .match_o   (fl_match)
  );

  logic [N-1:0][PL_W-1:0] payload;
  for (genvar g = 0; g < N; g++) begin : g_pl
    assign payload[g] = {ppn_q[g], glob_q[g], rd_q[g], wr_q[g]};
  end

  logic            sel_hit;
  logic [PL_W-1:0] sel_pl;

  tlb_prio_mux #(.N(N), .W(PL_W)) u_mux (
    .match_i (lkp_match),
    .data_i  (payload),
    .hit_o   (sel_hit),
    .data_o  (sel_pl)
  );

  tlb_slot_ptr #(.N(N)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_acc),
    .ptr_o  (slot_ptr)
  );

  // valid bits: flush has priority over fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      unique case (flush_op)
        FL_ALL:  valid_q <= '0;
        FL_PROC: valid_q <= valid_q & glob_q;
        FL_ADDR: valid_q <= valid_q & ~fl_match;
        default: if (fill_acc) valid_q[slot_ptr] <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= '0;
      tag_q  <= '0;
      asn_q  <= '0;
      ppn_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
    end else if (fill_acc) begin
      glob_q[slot_ptr] <= fill_glob_i;
      tag_q[slot_ptr]  <= fill_vpn_i;
      asn_q[slot_ptr]  <= fill_asn_i;
      ppn_q[slot_ptr]  <= fill_ppn_i;
      rd_q[slot_ptr]   <= fill_rd_en_i;
      wr_q[slot_ptr]   <= fill_wr_en_i;
    end
  end

  logic            res_valid_q, res_hit_q;
  logic [PL_W-1:0] res_pl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_pl_q    <= '0;
    end else begin
      res_valid_q <= lkp_acc;
      res_hit_q   <= lkp_acc && sel_hit;
      res_pl_q    <= (lkp_acc && sel_hit) ? sel_pl : '0;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_hit_o   = res_hit_q;
  assign {res_ppn_o, res_glob_o, res_rd_en_o, res_wr_en_o} = res_pl_q;
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int N     = 16,
  parameter int PPN_W = 16,
  parameter int PW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_valid_i,
  input logic             fill_valid_i,
  input logic [1:0]       flush_op_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [PPN_W-1:0] res_ppn_o,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     glob_vec,
  input logic [PW-1:0]    ptr
);
  p_res_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !fill_valid_i && flush_op_i == 2'd0) |=> res_valid_o);

  p_blocked_lookup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i || flush_op_i != 2'd0) |=> !res_valid_o);

  p_miss_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_ppn_o == '0));

  p_hit_needs_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);

  p_flush_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'd1) |=> (valid_vec == '0));

  p_proc_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'd2) |=> ((valid_vec & ~glob_vec) == '0 &&
                              valid_vec == ($past(valid_vec) & $past(glob_vec))));

  p_ptr_adv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && flush_op_i == 2'd0) |=>
      (ptr == (($past(ptr) == PW'(N - 1)) ? '0 : $past(ptr) + 1'b1)));

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i != 2'd0 || !fill_valid_i) |=> $stable(ptr));
endmodule

bind asn_tlb asn_tlb_chk #(
  .N     (NUM_ENTRIES),
  .PPN_W (PPN_W),
  .PW    (PW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .fill_valid_i (fill_valid_i),
  .flush_op_i   (flush_op_i),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .res_ppn_o    (res_ppn_o),
  .valid_vec    (valid_q),
  .glob_vec     (glob_q),
  .ptr          (slot_ptr)
);

// File: tb/asn_tlb_tb_top.sv
module asn_tlb_tb_top;
  localparam int VPN_W = 20;
  localparam int ASN_W = 8;
  localparam int PPN_W = 16;
  localparam int MODES = 4;
  localparam int N     = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic             lkp_valid_i = 0, fill_valid_i = 0, fill_glob_i = 0;
  logic [VPN_W-1:0] lkp_vpn_i = 0, fill_vpn_i = 0, flush_vpn_i = 0;
  logic [ASN_W-1:0] lkp_asn_i = 0, fill_asn_i = 0, flush_asn_i = 0;
  logic [PPN_W-1:0] fill_ppn_i = 0;
  logic [MODES-1:0] fill_rd_en_i = 0, fill_wr_en_i = 0;
  logic [1:0]       flush_op_i = 0;
  logic             res_valid_o, res_hit_o, res_glob_o;
  logic [PPN_W-1:0] res_ppn_o;
  logic [MODES-1:0] res_rd_en_o, res_wr_en_o;

  asn_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_vpn_i(lkp_vpn_i), .lkp_asn_i(lkp_asn_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_asn_i(fill_asn_i),
    .fill_glob_i(fill_glob_i), .fill_ppn_i(fill_ppn_i),
    .fill_rd_en_i(fill_rd_en_i), .fill_wr_en_i(fill_wr_en_i),
    .flush_op_i(flush_op_i), .flush_vpn_i(flush_vpn_i), .flush_asn_i(flush_asn_i),
    .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_ppn_o(res_ppn_o),
    .res_glob_o(res_glob_o), .res_rd_en_o(res_rd_en_o), .res_wr_en_o(res_wr_en_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lkp_valid_i = 0; fill_valid_i = 0; flush_op_i = 2'd0;
  endtask

  task automatic do_fill(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic g,
                         logic [PPN_W-1:0] p);
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = v; fill_asn_i = a; fill_glob_i = g;
    fill_ppn_i = p; fill_rd_en_i = p[3:0]; fill_wr_en_i = ~p[3:0];
    @(negedge clk);
    idle();
  endtask

  task automatic do_flush(logic [1:0] op, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
    @(negedge clk);
    flush_op_i = op; flush_vpn_i = v; flush_asn_i = a;
    @(negedge clk);
    idle();
  endtask

  task automatic do_lookup(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic eh,
                           logic [PPN_W-1:0] ep, string req);
    @(negedge clk);
    lkp_valid_i = 1; lkp_vpn_i = v; lkp_asn_i = a;
    @(negedge clk);
    idle();
    chk({req, " res_valid"}, 32'(res_valid_o), 32'd1);
    chk({req, " hit"}, 32'(res_hit_o), 32'(eh));
    chk({req, " ppn"}, 32'(res_ppn_o), 32'(eh ? ep : '0));
  endtask

  // op: 1 fill, 2 lookup, 3 flush all, 4 flush process, 5 flush address
  typedef struct packed {
    logic [2:0]  op;
    logic [19:0] vpn;
    logic [7:0]  asn;
    logic        glob;
    logic [15:0] ppn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 20'h10, 8'd1, 1'b0, 16'h0A1, 4'd5},
    '{3'd1, 20'h20, 8'd2, 1'b0, 16'h0B2, 4'd5},
    '{3'd1, 20'h30, 8'd1, 1'b1, 16'h0C3, 4'd5},
    '{3'd1, 20'h40, 8'd3, 1'b0, 16'h0D4, 4'd5},
    '{3'd2, 20'h10, 8'd1, 1'b1, 16'h0A1, 4'd3},  // R3 asn match
    '{3'd2, 20'h10, 8'd2, 1'b0, 16'h000, 4'd4},  // R4 asn mismatch misses
    '{3'd2, 20'h30, 8'd7, 1'b1, 16'h0C3, 4'd3},  // R3 global ignores asn
    '{3'd2, 20'h20, 8'd2, 1'b1, 16'h0B2, 4'd3},
    '{3'd2, 20'h50, 8'd1, 1'b0, 16'h000, 4'd4},
    '{3'd5, 20'h20, 8'd1, 1'b0, 16'h000, 4'd8},  // R8 wrong asn, no effect
    '{3'd2, 20'h20, 8'd2, 1'b1, 16'h0B2, 4'd8},
    '{3'd5, 20'h20, 8'd2, 1'b0, 16'h000, 4'd8},
    '{3'd2, 20'h20, 8'd2, 1'b0, 16'h000, 4'd8},
    '{3'd2, 20'h10, 8'd1, 1'b1, 16'h0A1, 4'd8},
    '{3'd4, 20'h00, 8'd0, 1'b0, 16'h000, 4'd7},
    '{3'd2, 20'h30, 8'd1, 1'b1, 16'h0C3, 4'd7},  // R7 global kept
    '{3'd2, 20'h10, 8'd1, 1'b0, 16'h000, 4'd7},
    '{3'd2, 20'h40, 8'd3, 1'b0, 16'h000, 4'd7},
    '{3'd1, 20'h60, 8'd4, 1'b0, 16'h0E5, 4'd5},
    '{3'd2, 20'h60, 8'd4, 1'b1, 16'h0E5, 4'd3},
    '{3'd3, 20'h00, 8'd0, 1'b0, 16'h000, 4'd6},
    '{3'd2, 20'h30, 8'd1, 1'b0, 16'h000, 4'd6}   // R6 global also gone
  };

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid in reset", 32'(res_valid_o), 32'd0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 res_valid after reset", 32'(res_valid_o), 32'd0);
    do_lookup(20'h0, 8'd0, 1'b0, '0, "R1 empty table");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        3'd1: do_fill(VECS[i].vpn, VECS[i].asn, VECS[i].glob, VECS[i].ppn);
        3'd2: do_lookup(VECS[i].vpn, VECS[i].asn, VECS[i].glob, VECS[i].ppn, tag);
        3'd3: do_flush(2'd1, VECS[i].vpn, VECS[i].asn);
        3'd4: do_flush(2'd2, VECS[i].vpn, VECS[i].asn);
        default: do_flush(2'd3, VECS[i].vpn, VECS[i].asn);
      endcase
    end

    // R2: result lasts one cycle only
    @(negedge clk);
    chk("R2 no result without lookup", 32'(res_valid_o), 32'd0);

    // R3/R4 attributes on hit and miss
    do_fill(20'h70, 8'd6, 1'b1, 16'h0F6);
    @(negedge clk);
    lkp_valid_i = 1; lkp_vpn_i = 20'h70; lkp_asn_i = 8'd2;
    @(negedge clk);
    idle();
    chk("R3 glob attr", 32'(res_glob_o), 32'd1);
    chk("R3 rd attr", 32'(res_rd_en_o), 32'h6);
    chk("R3 wr attr", 32'(res_wr_en_o), 32'h9);
    do_lookup(20'h71, 8'd6, 1'b0, '0, "R4 miss");
    chk("R4 rd zero on miss", 32'(res_rd_en_o), 32'd0);

    // R1 reset clears a global entry and the pointer
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    do_lookup(20'h70, 8'd6, 1'b0, '0, "R1 cleared by reset");

    // R5 wrap: NUM_ENTRIES + 1 fills
    for (int i = 0; i < N; i++) do_fill(20'h100 + 20'(i), 8'd9, 1'b0, 16'h100 + 16'(i));
    do_lookup(20'h100, 8'd9, 1'b1, 16'h100, "R5 slot0 before wrap");
    do_fill(20'h200, 8'd9, 1'b0, 16'h2AA);
    do_lookup(20'h100, 8'd9, 1'b0, '0, "R5 slot0 overwritten");
    do_lookup(20'h101, 8'd9, 1'b1, 16'h101, "R5 slot1 kept");
    do_lookup(20'h200, 8'd9, 1'b1, 16'h2AA, "R5 wrapped fill");

    // R9: flush + fill + lookup together
    @(negedge clk);
    flush_op_i = 2'd1; fill_valid_i = 1; fill_vpn_i = 20'h300; fill_asn_i = 8'd9;
    fill_glob_i = 1; fill_ppn_i = 16'h333;
    lkp_valid_i = 1; lkp_vpn_i = 20'h101; lkp_asn_i = 8'd9;
    @(negedge clk);
    idle();
    chk("R9 lookup blocked by flush", 32'(res_valid_o), 32'd0);
    do_lookup(20'h300, 8'd9, 1'b0, '0, "R9 fill blocked by flush");
    do_lookup(20'h101, 8'd9, 1'b0, '0, "R9 flush applied");

    // R9: fill + lookup together
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = 20'h310; fill_asn_i = 8'd9; fill_glob_i = 0;
    fill_ppn_i = 16'h310;
    lkp_valid_i = 1; lkp_vpn_i = 20'h310; lkp_asn_i = 8'd9;
    @(negedge clk);
    idle();
    chk("R9 lookup blocked by fill", 32'(res_valid_o), 32'd0);
    do_lookup(20'h310, 8'd9, 1'b1, 16'h310, "R9 fill done");

    // R10: duplicates in slots 2 and 3, lowest wins
    do_fill(20'h400, 8'd5, 1'b0, 16'h011);
    do_fill(20'h400, 8'd5, 1'b0, 16'h022);
    do_lookup(20'h400, 8'd5, 1'b1, 16'h011, "R10 lowest slot");
    // R8: address flush removes both matching copies
    do_flush(2'd3, 20'h400, 8'd5);
    do_lookup(20'h400, 8'd5, 1'b0, '0, "R8 all copies flushed");
    do_lookup(20'h310, 8'd9, 1'b1, 16'h310, "R8 other kept");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule